// File: doc/BRIEF.md
# Wait-for-event sleep controller

This block holds the one-bit event flag that a single-core processor consults when it executes a wait-for-event instruction, and it runs the handshake with the clock or power controller that puts the core to sleep and brings it back. A wait request either falls straight through by consuming a pending event, or it raises a sleep request and holds it until a send-event strobe or an interrupt arrives. The completion pulse is what lets the stalled instruction retire.

The flag is not a counter. Any number of events collapse into a single pending bit. An event that ends a sleep sets the flag and leaves it set, so the next wait request consumes it and does not sleep. A wait and an event that arrive in the same cycle never lose the wake-up: the event is seen first and the wait completes at once.

Top module: `wfe_sleep_ctrl`

## Requirements
- R1: On synchronous reset `evt_flag`, `sleep_req`, `wake` and `wait_done` are all 0, including when reset arrives while the block is asleep.
- R2: A high `send_evt`, or any single high bit of `irq_evt`, sets `evt_flag` to 1 in the following cycle.
- R3: Events do not accumulate. After several events with no wait in between, the first wait falls through and a second wait sleeps.
- R4: A wait request while running with `evt_flag` = 1 clears the flag and raises `wait_done` for one cycle on the next cycle, and `sleep_req` stays 0.
- R5: A wait request while running with `evt_flag` = 0 and no event present raises `sleep_req` on the next cycle. `sleep_req` then stays high until an event arrives, and `wait_done` stays 0.
- R6: An event seen while asleep drops `sleep_req` on the next cycle. In that same cycle `wake` and `wait_done` are high for exactly one cycle, and `evt_flag` reads 1 and stays 1.
- R7: In the order wait (sleeps), interrupt, wait, the second wait does not sleep. It clears the flag and completes on the next cycle.
- R8: A wait request and an event in the same cycle with `evt_flag` = 0 complete the wait on the next cycle without sleeping, and the flag then reads 0.
- R9: `wait_req` has no effect while `sleep_req` or `wake` is high.
- R10: A wait request and an event in the same cycle with `evt_flag` = 1 are covered by one completion, and the flag reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_req | input | 1 | Wait-for-event request strobe from the core |
| send_evt | input | 1 | Send-event strobe |
| irq_evt | input | IRQ_W | Interrupt taken or pending pulses, one bit per source |
| sleep_req | output | 1 | Request to the clock or power controller to enter low power |
| wake | output | 1 | One-cycle indication that a sleeping wait ended |
| evt_flag | output | 1 | Current value of the event flag |
| wait_done | output | 1 | One-cycle pulse that retires the wait instruction |

## Verification
Every cycle, the assertions check the local cause and effect rules: a pending flag turns a wait into an immediate completion, an empty flag turns a wait into a held sleep request, an event during sleep produces the one-cycle wake and completion with the flag set, a set flag stays set until a wait takes it, and the exit from reset is clean. Only the bench's scenarios can show the ordering effects that span several instructions. These are the wait, interrupt, wait sequence in which the second wait must not sleep, the collapse of repeated events into one so that the second of two waits does sleep, and the lack of any effect from wait requests issued during sleep or wake.

// File: rtl/wfe_pkg.sv
package wfe_pkg;

    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_SLEEP = 2'd1,
        PH_WAKE  = 2'd2
    } phase_e;

    // Per-cycle decisions of the sequencer.
    typedef struct packed {
        logic   take;     // clear the flag for a completing wait
        logic   done_set; // completion on the next cycle from a fall-through
        phase_e nxt;      // next phase
    } seq_dec_t;

    // Decide what a cycle does, given phase, request, flag and event.
    function automatic seq_dec_t decide(
        input phase_e ph,
        input logic   wreq,
        input logic   flag,
        input logic   evt
    );
        seq_dec_t d;
        d.take     = 1'b0;
        d.done_set = 1'b0;
        d.nxt      = ph;
        unique case (ph)
            PH_RUN: begin
                if (wreq) begin
                    if (flag || evt) begin
                        d.take     = 1'b1;
                        d.done_set = 1'b1;
                    end else begin
                        d.nxt = PH_SLEEP;
                    end
                end
            end
            PH_SLEEP: begin
                if (evt) begin
                    d.nxt = PH_WAKE;
                end
            end
            PH_WAKE: begin
                d.nxt = PH_RUN;
            end
            default: begin
                d.nxt = PH_RUN;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/wfe_evt_merge.sv
module wfe_evt_merge #(
    parameter int IRQ_W = 4
) (
    input  logic             send_evt,
    input  logic [IRQ_W-1:0] irq_evt,
    output logic             any_evt
);
    // Running OR over the interrupt sources, built one stage per bit.
    logic [IRQ_W:0] chain;

    assign chain[0] = send_evt;

    for (genvar g = 0; g < IRQ_W; g++) begin : g_or
        assign chain[g+1] = chain[g] | irq_evt[g];
    end

    assign any_evt = chain[IRQ_W];
endmodule

// File: rtl/wfe_flag_reg.sv
module wfe_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic take_i,
    output logic flag_o
);
    // Saturating one-bit flag. A take in the same cycle as a set wins,
    // because that wait has already accounted for the event.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else begin
            flag_o <= (flag_o | set_i) & ~take_i;
        end
    end
endmodule

// File: rtl/wfe_seq.sv
module wfe_seq
    import wfe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wreq_i,
    input  logic evt_i,
    input  logic flag_i,
    output logic take_o,
    output logic sleep_o,
    output logic wake_o,
    output logic done_o
);
    phase_e   ph_q;
    logic     fall_q;
    seq_dec_t dec;

    always_comb begin
        dec = decide(ph_q, wreq_i, flag_i, evt_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_RUN;
            fall_q <= 1'b0;
        end else begin
            ph_q   <= dec.nxt;
            fall_q <= dec.done_set;
        end
    end

    assign take_o  = dec.take;
    assign sleep_o = (ph_q == PH_SLEEP);
    assign wake_o  = (ph_q == PH_WAKE);
    assign done_o  = fall_q | (ph_q == PH_WAKE);
endmodule

// File: rtl/wfe_sleep_ctrl.sv
module wfe_sleep_ctrl #(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wait_req,
    input  logic             send_evt,
    input  logic [IRQ_W-1:0] irq_evt,
    output logic             sleep_req,
    output logic             wake,
    output logic             evt_flag,
    output logic             wait_done
);
    logic any_evt;
    logic take;

    wfe_evt_merge #(.IRQ_W(IRQ_W)) merge_i (
        .send_evt (send_evt),
        .irq_evt  (irq_evt),
        .any_evt  (any_evt)
    );

    wfe_flag_reg flag_i (
        .clk    (clk),
        .rst    (rst),
        .set_i  (any_evt),
        .take_i (take),
        .flag_o (evt_flag)
    );

    wfe_seq seq_i (
        .clk     (clk),
        .rst     (rst),
        .wreq_i  (wait_req),
        .evt_i   (any_evt),
        .flag_i  (evt_flag),
        .take_o  (take),
        .sleep_o (sleep_req),
        .wake_o  (wake),
        .done_o  (wait_done)
    );
endmodule

// File: rtl/wfe_sleep_ctrl_chk.sv
module wfe_sleep_ctrl_chk #(
    parameter int IRQ_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wait_req,
    input logic             send_evt,
    input logic [IRQ_W-1:0] irq_evt,
    input logic             sleep_req,
    input logic             wake,
    input logic             evt_flag,
    input logic             wait_done
);
    logic ev;
    logic running;
    logic rst_d = 1'b0;

    assign ev      = send_evt | (|irq_evt);
    assign running = !sleep_req && !wake;

    always_ff @(posedge clk) begin
        rst_d <= rst;
    end

    always @(posedge clk) begin
        if (rst_d && !rst) begin
            AST_RESET_IDLE: assert (!sleep_req && !wake && !evt_flag && !wait_done); // R1
        end
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        (ev && !(running && wait_req)) |=> evt_flag); // R2

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (evt_flag && !(running && wait_req)) |=> evt_flag); // R3

    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (running && wait_req && evt_flag) |=> (wait_done && !evt_flag && !sleep_req)); // R4

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (running && wait_req && !evt_flag && !ev) |=> (sleep_req && !wait_done)); // R5

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && !ev) |=> (sleep_req && !wait_done)); // R5

    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && ev) |=> (!sleep_req && wake && wait_done && evt_flag)); // R6

    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wake |=> (!wake && !wait_done && !sleep_req)); // R9

    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (running && wait_req && ev) |=> (wait_done && !sleep_req && !evt_flag)); // R8
endmodule

bind wfe_sleep_ctrl wfe_sleep_ctrl_chk #(.IRQ_W(IRQ_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wait_req  (wait_req),
    .send_evt  (send_evt),
    .irq_evt   (irq_evt),
    .sleep_req (sleep_req),
    .wake      (wake),
    .evt_flag  (evt_flag),
    .wait_done (wait_done)
);

// File: tb/wfe_sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module wfe_sleep_ctrl_tb_top;
    localparam int IRQ_W = 4;
    localparam int NV    = 25;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wait_req = 1'b0;
    logic             send_evt = 1'b0;
    logic [IRQ_W-1:0] irq_evt = '0;
    logic             sleep_req, wake, evt_flag, wait_done;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    wfe_sleep_ctrl #(.IRQ_W(IRQ_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .wait_req  (wait_req),
        .send_evt  (send_evt),
        .irq_evt   (irq_evt),
        .sleep_req (sleep_req),
        .wake      (wake),
        .evt_flag  (evt_flag),
        .wait_done (wait_done)
    );

    // Each entry: {wait, send, irq | exp sleep, exp wake, exp flag, exp done}.
    // Expected values are the outputs after the edge that samples the inputs.
    localparam logic [6:0] VEC [NV] = '{
        7'b000_0000, // idle after reset                 R1
        7'b100_1000, // wait with empty flag sleeps      R5
        7'b000_1000, // sleep holds                      R5
        7'b100_1000, // wait while asleep ignored        R9
        7'b001_0111, // interrupt wakes, flag kept       R6
        7'b000_0010, // pulse over, flag still 1         R6
        7'b100_0001, // second wait falls through        R7
        7'b000_0000,
        7'b010_0010, // send sets flag                   R2
        7'b100_0001, // event then wait                  R4
        7'b000_0000,
        7'b010_0010, // event
        7'b001_0010, // event again: saturates           R3
        7'b011_0010, // both at once: still one          R3
        7'b100_0001, // first wait consumes              R3
        7'b000_0000,
        7'b100_1000, // second wait sleeps               R3
        7'b010_0111, // send wakes                       R6
        7'b100_0010, // wait during wake ignored         R9
        7'b100_0001, // then falls through               R4
        7'b110_0001, // wait and event, flag 0           R8
        7'b000_0000,
        7'b010_0010, // set flag
        7'b110_0001, // wait and event, flag 1           R10
        7'b000_0000  // flag stays 0                     R10
    };

    function automatic string req_of(input int k);
        case (k)
            0:                        return "R1";
            1, 2:                     return "R5";
            3, 18:                    return "R9";
            4, 5, 17:                 return "R6";
            6:                        return "R7";
            8:                        return "R2";
            9, 19:                    return "R4";
            11, 12, 13, 14, 15, 16:   return "R3";
            20:                       return "R8";
            22, 23, 24:               return "R10";
            default:                  return "R4";
        endcase
    endfunction

    task automatic check4(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {sleep_req, wake, evt_flag, wait_done};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {sleep,wake,flag,done} actual=%b expected=%b at %0t",
                     req, act, exp, $time);
        end
    endtask

    task automatic apply(input logic w, input logic s, input logic [IRQ_W-1:0] i);
        @(negedge clk);
        wait_req = w;
        send_evt = s;
        irq_evt  = i;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        check4("R1", 4'b0000);

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][6], VEC[k][5],
                  VEC[k][4] ? IRQ_W'(1) << (k % IRQ_W) : '0);
            check4(req_of(k), VEC[k][3:0]);
        end

        // R2: each interrupt source alone wakes a sleeping wait.
        for (int b = 0; b < IRQ_W; b++) begin
            apply(1'b1, 1'b0, '0);
            check4("R5", 4'b1000);
            apply(1'b0, 1'b0, IRQ_W'(1) << b);
            check4("R2", 4'b0111);
            apply(1'b1, 1'b0, '0);
            check4("R2", 4'b0010);
            apply(1'b1, 1'b0, '0);
            check4("R7", 4'b0001);
            apply(1'b0, 1'b0, '0);
            check4("R4", 4'b0000);
        end

        // R1: reset while asleep with a pending flag path.
        apply(1'b1, 1'b0, '0);
        check4("R5", 4'b1000);
        @(negedge clk);
        wait_req = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check4("R1", 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        apply(1'b0, 1'b0, '0);
        check4("R1", 4'b0000);

        // R1: reset clears a set flag.
        apply(1'b0, 1'b1, '0);
        check4("R2", 4'b0010);
        @(negedge clk);
        send_evt = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check4("R1", 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        apply(1'b1, 1'b0, '0);
        check4("R5", 4'b1000);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule